// File: doc/BRIEF.md
# Serial In-System Programming Controller

This block is the target-side engine that an external programmer talks to over a four-wire-style serial link (clock, data in, data out) while the device is held in its programming state. It samples the serial clock and input line with the fast system clock, assembles fixed-length instruction frames and drives the serial output. Two separate byte-wide non-volatile stores are modelled: a code array and a smaller data array. It carries out byte stores, byte reads, a whole-device erase and a lock-bit store.

A session opens when the hold input goes high and closes when it falls. Nothing but the unlock instruction is honoured until that instruction has completed in the current session. Every store is self-timed: the block reports busy for a fixed, parameter-set number of system cycles, and it drops any frame that completes during that time. A byte store replaces the previous content outright, because the cell is erased as part of the store. Programmed lock bits block stores until a whole-device erase clears them.

Top module: `isp_ctrl`

## Requirements
- R1: When `isp_hold` is low, or `rst_n` is low, the frame bit position returns to the start and `miso` is low. Dropping `isp_hold` also revokes the unlock, so a later store with no new unlock has no effect.
- R2: After the session opens, only a completed unlock frame (opcode 0xAC) permits other instructions. Before it, a read returns 0x00 and stores and erases leave the arrays unchanged and `busy` low.
- R3: A byte store (code opcode 0x40, data opcode 0xC0) leaves exactly the sent byte at the address, whatever the location held before.
- R4: A store or lock store holds `busy` high for exactly WR_CYCLES system cycles. Any frame that completes while `busy` is high is discarded, and a read during that time returns 0x00.
- R5: The erase opcode 0x80 sets every location in both arrays to 0xFF and holds `busy` high for 2^max(CODE_AW,DATA_AW) cycles.
- R6: The lock-store opcode 0xE0 sets lock bits from bits [1:0] of the fourth byte (bits already set stay set). While any lock bit is set, byte stores do nothing and do not raise `busy`. An erase clears the lock bits.
- R7: The code and data arrays are separate address spaces, chosen by opcode. A store to one never changes the other.
- R8: Address bits above the selected array's width are ignored, so addresses wrap within that array.
- R9: A frame is 32 bits sent MSB first: opcode, address high byte, address low byte, then a data byte. Input is taken on the rising `sck` edge and output changes on the falling edge. For reads (code opcode 0x20, data opcode 0xA0) the stored byte appears MSB first on `miso` during the fourth byte.
- R10: An opcode outside the listed set has no effect on any array or on `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; `sck` must run below 1/40 of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| isp_hold | input | 1 | High while the device is held for programming; opens the session |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial read data to the programmer |
| busy | output | 1 | High while a timed store or an erase is running |

## Verification
The bench builds the block with a 64-byte code array, a 32-byte data array and WR_CYCLES of 1500. That makes a full erase sweep short enough to time exactly. It also puts the wrap-around of a high address such as 0x1FC5 within reach of a short vector table. Because WR_CYCLES exceeds the length of one serial frame at 42 system cycles per bit, a second store sent straight after a first one lands inside the busy window. This exercises the discard path without any special timing.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS   = 24;
  localparam int LOCK_BITS  = 2;

  localparam logic [7:0] OPC_UNLOCK  = 8'hAC;
  localparam logic [7:0] OPC_ST_CODE = 8'h40;
  localparam logic [7:0] OPC_LD_CODE = 8'h20;
  localparam logic [7:0] OPC_ST_DATA = 8'hC0;
  localparam logic [7:0] OPC_LD_DATA = 8'hA0;
  localparam logic [7:0] OPC_ERASE   = 8'h80;
  localparam logic [7:0] OPC_ST_LOCK = 8'hE0;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_UNLOCK,
    CMD_ST_CODE,
    CMD_LD_CODE,
    CMD_ST_DATA,
    CMD_LD_DATA,
    CMD_ERASE,
    CMD_ST_LOCK
  } isp_cmd_e;

  typedef struct packed {
    logic [7:0]  opc;
    logic [15:0] addr;
    logic [7:0]  dat;
  } isp_frame_t;

  function automatic isp_cmd_e decode_opc(input logic [7:0] opc);
    case (opc)
      OPC_UNLOCK:  return CMD_UNLOCK;
      OPC_ST_CODE: return CMD_ST_CODE;
      OPC_LD_CODE: return CMD_LD_CODE;
      OPC_ST_DATA: return CMD_ST_DATA;
      OPC_LD_DATA: return CMD_LD_DATA;
      OPC_ERASE:   return CMD_ERASE;
      OPC_ST_LOCK: return CMD_ST_LOCK;
      default:     return CMD_NONE;
    endcase
  endfunction

  function automatic logic is_load(input isp_cmd_e c);
    return (c == CMD_LD_CODE) || (c == CMD_LD_DATA);
  endfunction

  function automatic logic [LOCK_BITS-1:0] merge_lock(input logic [LOCK_BITS-1:0] held,
                                                      input logic [LOCK_BITS-1:0] req);
    return held | req;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] mosi_q;
  logic              sck_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q  <= '0;
          mosi_q <= '0;
        end else begin
          sck_q  <= sck;
          mosi_q <= mosi;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q  <= '0;
          mosi_q <= '0;
        end else begin
          sck_q  <= {sck_q[STAGES-2:0], sck};
          mosi_q <= {mosi_q[STAGES-2:0], mosi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_q[STAGES-1];
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign mosi_s   = mosi_q[STAGES-1];

endmodule

// File: rtl/isp_shifter.sv
module isp_shifter import isp_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  session,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  mosi_s,
  input  logic                  rd_load,
  input  logic [7:0]            rd_byte,
  output logic [FRAME_BITS-1:0] word_next,
  output logic                  hdr_done,
  output logic                  frame_done,
  output logic                  miso
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] HDR_POS  = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] DAT_POS  = CW'(HDR_BITS);

  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] in_sr;
  logic [7:0]            out_sr;

  assign word_next  = {in_sr[FRAME_BITS-2:0], mosi_s};
  assign hdr_done   = session && sck_rise && (cnt == HDR_POS);
  assign frame_done = session && sck_rise && (cnt == LAST_POS);
  assign miso       = out_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      in_sr  <= '0;
      out_sr <= '0;
    end else if (!session) begin
      cnt    <= '0;
      in_sr  <= '0;
      out_sr <= '0;
    end else begin
      if (sck_rise) begin
        in_sr <= word_next;
        cnt   <= (cnt == LAST_POS) ? '0 : cnt + CW'(1);
      end
      if (hdr_done) begin
        out_sr <= rd_load ? rd_byte : 8'h00;
      end else if (sck_fall && ((cnt > DAT_POS) || (cnt == '0))) begin
        out_sr <= {out_sr[6:0], 1'b0};
      end
    end
  end

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !session |=> !miso); // R1

endmodule

// File: rtl/isp_mem.sv
module isp_mem #(
  parameter int CODE_AW   = 10,
  parameter int DATA_AW   = 9,
  parameter int WR_CYCLES = 48000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        timed_start,
  input  logic        st_code,
  input  logic        st_data,
  input  logic [15:0] st_addr,
  input  logic [7:0]  st_byte,
  input  logic        erase_start,
  input  logic        ld_data,
  input  logic [15:0] ld_addr,
  output logic [7:0]  ld_byte,
  output logic        erase_done,
  output logic        busy
);
  localparam int CODE_DEPTH = 1 << CODE_AW;
  localparam int DATA_DEPTH = 1 << DATA_AW;
  localparam int SW         = isp_pkg::max_int(CODE_AW, DATA_AW);
  localparam int TW         = $clog2(WR_CYCLES + 1);
  localparam logic [SW-1:0] SWEEP_LAST = {SW{1'b1}};

  logic [7:0]    code_mem [CODE_DEPTH];
  logic [7:0]    data_mem [DATA_DEPTH];
  logic [SW-1:0] sweep;
  logic          erasing;
  logic [TW-1:0] timer;
  logic          unused_addr;

  assign unused_addr = ^{st_addr, ld_addr};
  assign erase_done  = erasing && (sweep == SWEEP_LAST);
  assign busy        = erasing || (timer != '0);
  assign ld_byte     = ld_data ? data_mem[ld_addr[DATA_AW-1:0]]
                               : code_mem[ld_addr[CODE_AW-1:0]];

  always_ff @(posedge clk) begin
    if (erasing) begin
      code_mem[sweep[CODE_AW-1:0]] <= 8'hFF;
      data_mem[sweep[DATA_AW-1:0]] <= 8'hFF;
    end else begin
      if (st_code) code_mem[st_addr[CODE_AW-1:0]] <= st_byte;
      if (st_data) data_mem[st_addr[DATA_AW-1:0]] <= st_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erasing <= 1'b0;
      sweep   <= '0;
    end else if (erase_start) begin
      erasing <= 1'b1;
      sweep   <= '0;
    end else if (erasing) begin
      if (sweep == SWEEP_LAST) erasing <= 1'b0;
      sweep <= sweep + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                timer <= '0;
    else if (timed_start)      timer <= TW'(WR_CYCLES);
    else if (timer != '0)      timer <= timer - TW'(1);
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_start || erase_start) |-> !busy); // R4
  AST_STORE_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    timed_start |=> busy); // R4
  AST_NO_STORE_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> !(st_code || st_data)); // R5

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl import isp_pkg::*; #(
  parameter int CODE_AW     = 10,
  parameter int DATA_AW     = 9,
  parameter int WR_CYCLES   = 48000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic isp_hold,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);
  logic                  sck_rise, sck_fall, mosi_s;
  logic [FRAME_BITS-1:0] word_next;
  logic                  hdr_done, frame_done;
  logic                  rd_load;
  logic [7:0]            rd_byte;
  logic                  unlocked;
  logic [LOCK_BITS-1:0]  lock_q;
  logic                  erase_done;
  isp_frame_t            frm;
  isp_cmd_e              hdr_cmd, frm_cmd;
  logic [15:0]           hdr_addr;
  logic                  go, store_ok;
  logic                  st_code, st_data, lock_req, erase_req, timed_start;

  isp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  isp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .session(isp_hold),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .rd_load(rd_load), .rd_byte(rd_byte),
    .word_next(word_next), .hdr_done(hdr_done), .frame_done(frame_done),
    .miso(miso)
  );

  // header view (first three bytes) and full-frame view
  assign hdr_cmd  = decode_opc(word_next[HDR_BITS-1:HDR_BITS-8]);
  assign hdr_addr = word_next[15:0];
  assign frm      = isp_frame_t'(word_next);
  assign frm_cmd  = decode_opc(frm.opc);

  assign rd_load     = hdr_done && unlocked && !busy && is_load(hdr_cmd);
  assign go          = frame_done && unlocked && !busy;
  assign store_ok    = go && (lock_q == '0);
  assign st_code     = store_ok && (frm_cmd == CMD_ST_CODE);
  assign st_data     = store_ok && (frm_cmd == CMD_ST_DATA);
  assign lock_req    = go && (frm_cmd == CMD_ST_LOCK);
  assign erase_req   = go && (frm_cmd == CMD_ERASE);
  assign timed_start = st_code || st_data || lock_req;

  isp_mem #(.CODE_AW(CODE_AW), .DATA_AW(DATA_AW), .WR_CYCLES(WR_CYCLES)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .timed_start(timed_start), .st_code(st_code), .st_data(st_data),
    .st_addr(frm.addr), .st_byte(frm.dat),
    .erase_start(erase_req),
    .ld_data(hdr_cmd == CMD_LD_DATA), .ld_addr(hdr_addr), .ld_byte(rd_byte),
    .erase_done(erase_done), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                              unlocked <= 1'b0;
    else if (!isp_hold)                                      unlocked <= 1'b0;
    else if (frame_done && !busy && frm_cmd == CMD_UNLOCK)   unlocked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lock_q <= '0;
    else if (erase_done) lock_q <= '0;
    else if (lock_req)   lock_q <= merge_lock(lock_q, frm.dat[LOCK_BITS-1:0]);
  end

  AST_SESSION_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    !isp_hold |=> !unlocked); // R1
  AST_GATED_BY_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_start || erase_req || rd_load) |-> unlocked); // R2
  AST_LOCK_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code || st_data) |-> (lock_q == '0)); // R6
  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> (lock_q == '0)); // R6

endmodule

// File: tb/isp_ctrl_tb.sv
`timescale 1ns/1ps
module isp_ctrl_tb;
  localparam int CODE_AW   = 6;
  localparam int DATA_AW   = 5;
  localparam int WR_CYCLES = 1500;
  localparam int HALF      = 21;
  localparam int ERASE_LEN = 1 << CODE_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic isp_hold = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, busy;

  int checks = 0;
  int errors = 0;
  int run = 0;
  int last_run = 0;

  always #2.5 clk = ~clk;

  isp_ctrl #(.CODE_AW(CODE_AW), .DATA_AW(DATA_AW), .WR_CYCLES(WR_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .isp_hold(isp_hold), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy)
  );

  // busy pulse length monitor
  always @(negedge clk) begin
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  // kind[41:40] 0=store then wait idle, 1=read and compare; opc, addr, data, expected
  localparam logic [41:0] VEC [15] = '{
    {2'd0, 8'h40, 16'h0003, 8'h3C, 8'h00},
    {2'd1, 8'h20, 16'h0003, 8'h00, 8'h3C},  // R9
    {2'd0, 8'h40, 16'h0003, 8'h0F, 8'h00},
    {2'd1, 8'h20, 16'h0003, 8'h00, 8'h0F},  // R3
    {2'd0, 8'hC0, 16'h0003, 8'hA5, 8'h00},
    {2'd1, 8'h20, 16'h0003, 8'h00, 8'h0F},  // R7
    {2'd1, 8'hA0, 16'h0003, 8'h00, 8'hA5},  // R7
    {2'd0, 8'h40, 16'h1FC5, 8'h77, 8'h00},
    {2'd1, 8'h20, 16'h0005, 8'h00, 8'h77},  // R8
    {2'd1, 8'hA0, 16'h07E3, 8'h00, 8'hA5},  // R8
    {2'd0, 8'h55, 16'h0003, 8'h00, 8'h00},
    {2'd1, 8'h20, 16'h0003, 8'h00, 8'h0F},  // R10
    {2'd1, 8'h20, 16'h0009, 8'h00, 8'hFF},
    {2'd0, 8'hC0, 16'h001F, 8'h5A, 8'h00},
    {2'd1, 8'hA0, 16'h001F, 8'h00, 8'h5A}   // R9
  };

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] opc, input logic [15:0] addr,
                       input logic [7:0] dat, output logic [7:0] rd);
    logic [31:0] w;
    w  = {opc, addr, dat};
    rd = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      mosi = w[i];
      repeat (HALF) @(negedge clk);
      if (i < 8) rd = {rd[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  logic [7:0] rd;

  initial begin
    repeat (5) @(negedge clk);
    chk8("R1 reset busy", 8'(busy), 8'h00);
    chk8("R1 reset miso", 8'(miso), 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    isp_hold = 1'b1;
    repeat (3) @(negedge clk);

    // R2: nothing honoured before unlock
    frame(8'h20, 16'h0000, 8'h00, rd);
    chk8("R2 read before unlock", rd, 8'h00);
    frame(8'h80, 16'h0000, 8'h00, rd);
    chk8("R2 erase before unlock busy", 8'(busy), 8'h00);

    // R5: erase after unlock
    frame(8'hAC, 16'h0000, 8'h00, rd);
    frame(8'h80, 16'h0000, 8'h00, rd);
    wait_idle();
    chk_int("R5 erase busy length", last_run, ERASE_LEN);
    frame(8'h20, 16'h0000, 8'h00, rd); chk8("R5 code low", rd, 8'hFF);
    frame(8'h20, 16'h003F, 8'h00, rd); chk8("R5 code top", rd, 8'hFF);
    frame(8'hA0, 16'h001F, 8'h00, rd); chk8("R5 data top", rd, 8'hFF);

    // R1: closing the session revokes unlock
    isp_hold = 1'b0;
    repeat (5) @(negedge clk);
    chk8("R1 miso with hold low", 8'(miso), 8'h00);
    isp_hold = 1'b1;
    repeat (3) @(negedge clk);
    frame(8'h40, 16'h0005, 8'h12, rd);
    chk8("R1 store after reopen busy", 8'(busy), 8'h00);
    frame(8'hAC, 16'h0000, 8'h00, rd);
    frame(8'h20, 16'h0005, 8'h00, rd);
    chk8("R1 store after reopen ignored", rd, 8'hFF);

    // vector table: R3 R7 R8 R9 R10
    foreach (VEC[i]) begin
      frame(VEC[i][39:32], VEC[i][31:16], VEC[i][15:8], rd);
      if (VEC[i][41:40] == 2'd0) wait_idle();
      else chk8($sformatf("vector %0d read", i), rd, VEC[i][7:0]);
    end

    // R4: busy length and discard
    frame(8'h40, 16'h0007, 8'h11, rd);
    chk8("R4 busy after store", 8'(busy), 8'h01);
    frame(8'h40, 16'h0007, 8'h22, rd);
    wait_idle();
    chk_int("R4 busy length", last_run, WR_CYCLES);
    frame(8'h20, 16'h0007, 8'h00, rd);
    chk8("R4 store during busy discarded", rd, 8'h11);
    frame(8'h40, 16'h0008, 8'h33, rd);
    frame(8'h20, 16'h0008, 8'h00, rd);
    chk8("R4 read during busy", rd, 8'h00);
    wait_idle();
    frame(8'h20, 16'h0008, 8'h00, rd);
    chk8("R4 store landed", rd, 8'h33);

    // R6: lock bits
    frame(8'hE0, 16'h0000, 8'h01, rd);
    wait_idle();
    frame(8'h40, 16'h0003, 8'h99, rd);
    chk8("R6 locked store busy", 8'(busy), 8'h00);
    frame(8'hC0, 16'h0004, 8'h55, rd);
    frame(8'h20, 16'h0003, 8'h00, rd);
    chk8("R6 locked code store", rd, 8'h0F);
    frame(8'hA0, 16'h0004, 8'h00, rd);
    chk8("R6 locked data store", rd, 8'hFF);
    frame(8'h80, 16'h0000, 8'h00, rd);
    wait_idle();
    frame(8'h20, 16'h0003, 8'h00, rd);
    chk8("R6 erase wipes", rd, 8'hFF);
    frame(8'h40, 16'h0003, 8'h44, rd);
    wait_idle();
    frame(8'h20, 16'h0003, 8'h00, rd);
    chk8("R6 store after erase", rd, 8'h44);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule